// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block produces the address sequence for a four-beat burst into a pipelined memory. An accepted address strobe captures the full address. The low two bits become the starting offset of the burst, and the remaining upper bits are held for the whole burst. Each later clock with the advance input low steps to the next beat. The beat order is either interleaved, where the low bits are the start XOR the beat number, or linear, where they are the start plus the beat number modulo four. A static order-select input chooses between them.

There are two address strobes. The processor strobe is qualified by an active-low chip enable. The controller strobe is not. A strobe that is loading always overrides the advance input. All control pins are plain level signals. No data flows through the block, so it has no valid/ready handshake. The address is valid on every cycle after reset.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and until the first load, burst_addr_o is all zeros.
- R2: At a clock edge where proc_stb_n is 0 and ce1_n is 0, the address is loaded: on the following cycle burst_addr_o equals the addr_i sampled at that edge. This holds whether or not ctrl_stb_n is also 0.
- R3: At a clock edge where ctrl_stb_n is 0, the address is loaded whatever the value of ce1_n.
- R4: When ce1_n is 1, proc_stb_n has no effect. If ctrl_stb_n is 1 at such an edge, the cycle is handled as a non-load cycle.
- R5: At a load edge, adv_n is ignored. The beat number restarts at 0, so the output low bits equal addr_i[1:0].
- R6: With order_sel = 1 (interleaved), the low two bits at beat b are start XOR b.
- R7: With order_sel = 0 (linear), the low two bits at beat b are (start + b) mod 4.
- R8: At an edge with no load and adv_n = 1, burst_addr_o is unchanged.
- R9: At an edge with no load and adv_n = 0, the beat number increments. After beat 3 it wraps to beat 0, which gives the starting offset again.
- R10: The upper ADDR_W-2 bits of burst_addr_o change only at a load edge. addr_i is ignored on non-load edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (16) | Address sampled on a load edge |
| proc_stb_n | input | 1 | Processor address strobe, active low, qualified by ce1_n |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable gating the processor strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear; kept static during a burst |
| burst_addr_o | output | ADDR_W (16) | Captured upper bits joined with current beat's low bits |

## Verification
Loading and advancing can be requested in the same cycle. To provoke this, a strobe is asserted with adv_n low in the middle of a running burst. The check is that the next output is the freshly sampled address and not the next beat of the old burst. A second collision is the processor strobe arriving with ce1_n high while adv_n is low. In that case the old burst must step forward and the new addr_i must be ignored. Both strobes are also asserted together, with the chip enable low and with it high, and in each case the expected loaded value is checked.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;

  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input order_e     ord);
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    else                       return start + beat;
  endfunction
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
  input  logic proc_stb_n,
  input  logic ctrl_stb_n,
  input  logic ce1_n,
  input  logic adv_n,
  output logic load,
  output logic step
);
  logic proc_ok;
  always_comb begin
    proc_ok = !proc_stb_n && !ce1_n;
    load    = proc_ok || !ctrl_stb_n;
    step    = !load && !adv_n;
  end
endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output logic [BEAT_W-1:0]        start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (load) begin
      upper_q <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
    end
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    beat_q <= '0;
    else if (load) beat_q <= '0;
    else if (step) beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              ce1_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] burst_addr_o
);
  localparam int BEAT_W  = 2;
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic               load, step;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q, beat_q;
  order_e             ord;

  burst_load_ctl u_ctl (
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .ce1_n(ce1_n),
    .adv_n(adv_n), .load(load), .step(step)
  );

  burst_capture #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_i(addr_i),
    .upper_q(upper_q), .start_q(start_q)
  );

  beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .beat_q(beat_q)
  );

  always_comb begin
    ord          = order_e'(order_sel);
    burst_addr_o = {upper_q, beat_offset(start_q, beat_q, ord)};
  end
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              ce1_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] burst_addr_o
);
  logic ld_req;
  assign ld_req = (!proc_stb_n && !ce1_n) || !ctrl_stb_n;

  // R2 R3 R5
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> burst_addr_o == $past(addr_i));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_req && adv_n) |=> ($stable(burst_addr_o) || order_sel != $past(order_sel)));

  // R10
  a_r10_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> burst_addr_o[ADDR_W-1:2] == $past(burst_addr_o[ADDR_W-1:2]));

  // R7
  a_r7_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_req && !adv_n && !order_sel) |=>
      (order_sel || burst_addr_o[1:0] == $past(burst_addr_o[1:0]) + 2'd1));

  // R6
  a_r6_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_req && !adv_n && order_sel) |=>
      (!order_sel || burst_addr_o[0] != $past(burst_addr_o[0])));
endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .proc_stb_n(proc_stb_n),
  .ctrl_stb_n(ctrl_stb_n), .ce1_n(ce1_n), .adv_n(adv_n),
  .order_sel(order_sel), .burst_addr_o(burst_addr_o)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr_i = '0;
  logic        proc_stb_n = 1, ctrl_stb_n = 1, ce1_n = 1, adv_n = 1, order_sel = 1;
  logic [15:0] burst_addr_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  burst_addr_gen u0 (.*);

  // fields: req[3:0], proc_stb_n, ctrl_stb_n, ce1_n, adv_n, order_sel, addr[15:0], expected[15:0]
  localparam int NV = 27;
  localparam logic [40:0] VEC [0:NV-1] = '{
    {4'd2,  5'b01001, 16'h1235, 16'h1235}, // R2 proc load, start 01
    {4'd6,  5'b11101, 16'h0000, 16'h1234}, // R6 01^1
    {4'd6,  5'b11101, 16'h0000, 16'h1237}, // R6 01^2
    {4'd8,  5'b11111, 16'hFFFF, 16'h1237}, // R8 hold, R10 addr ignored
    {4'd10, 5'b11101, 16'hFFFF, 16'h1236}, // R10 upper kept, 01^3
    {4'd9,  5'b11101, 16'h0000, 16'h1235}, // R9 wrap
    {4'd5,  5'b10100, 16'hABCE, 16'hABCE}, // R3 R5 ctrl load with adv low
    {4'd7,  5'b11100, 16'h0000, 16'hABCF}, // R7 linear
    {4'd7,  5'b11100, 16'h0000, 16'hABCC}, // R7
    {4'd7,  5'b11100, 16'h0000, 16'hABCD}, // R7
    {4'd9,  5'b11100, 16'h0000, 16'hABCE}, // R9 wrap linear
    {4'd4,  5'b01110, 16'h0000, 16'hABCE}, // R4 proc ignored, hold
    {4'd4,  5'b01100, 16'h0000, 16'hABCF}, // R4 proc ignored, advance
    {4'd2,  5'b00001, 16'h5553, 16'h5553}, // R2 both strobes
    {4'd6,  5'b11101, 16'h0000, 16'h5552}, // R6
    {4'd6,  5'b11101, 16'h0000, 16'h5551}, // R6
    {4'd6,  5'b11101, 16'h0000, 16'h5550}, // R6
    {4'd3,  5'b00110, 16'h2220, 16'h2220}, // R3 both strobes, ce1 high
    {4'd11, 5'b11100, 16'h0000, 16'h2221}, // R7 (order 0)
    {4'd7,  5'b11100, 16'h0000, 16'h2222},
    {4'd7,  5'b11100, 16'h0000, 16'h2223},
    {4'd9,  5'b11100, 16'h0000, 16'h2220}, // R9
    {4'd3,  5'b10111, 16'h0F00, 16'h0F00}, // R3 ctrl load, start 00
    {4'd6,  5'b11101, 16'h0000, 16'h0F01},
    {4'd6,  5'b11101, 16'h0000, 16'h0F02},
    {4'd6,  5'b11101, 16'h0000, 16'h0F03},
    {4'd9,  5'b11101, 16'h0000, 16'h0F00}
  };

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (burst_addr_o !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, burst_addr_o, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", 16'h0000);
    rst_n = 1;
    @(negedge clk);
    check("R1", 16'h0000);
    for (int i = 0; i < NV; i++) begin
      {proc_stb_n, ctrl_stb_n, ce1_n, adv_n, order_sel} = VEC[i][36:32];
      addr_i = VEC[i][31:16];
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][40:37] == 4'd11 ? 7 : VEC[i][40:37]), VEC[i][15:0]);
    end
    // R5: load in the middle of a burst restarts at the new start
    {proc_stb_n, ctrl_stb_n, ce1_n, adv_n, order_sel} = 5'b11101;
    @(negedge clk);
    {proc_stb_n, ctrl_stb_n, ce1_n, adv_n} = 4'b0100;
    addr_i = 16'h7776;
    @(negedge clk);
    check("R5", 16'h7776);
    {proc_stb_n, ctrl_stb_n, ce1_n, adv_n} = 4'b1110;
    @(negedge clk);
    check("R5", 16'h7777);
    // R1: reset mid-burst
    rst_n = 0;
    #1;
    check("R1", 16'h0000);
    @(negedge clk);
    check("R1", 16'h0000);
    rst_n = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule